// File: doc/BRIEF.md
# DMA Channel Suspend/Resume Controller

This block is the control state machine for one channel of a DMA engine. It decides, cycle by cycle, whether the channel is idle, moving data, draining a beat before it pauses, paused, or stopped on a fault. It drives the run-enable that lets the transfer engine issue beats. It keeps three interrupt flags (block done, paused, fault) and emits a one-cycle event strobe and a trigger strobe.

Software controls the channel with one-cycle pulses: start, hold, release and abort. A one-cycle event input carries a configurable 3-bit action. The transfer engine reports three things to the block:
- beat activity,
- the end of each block, together with that descriptor's 2-bit block action and a last-block marker,
- bus errors and invalid descriptors.

A pause can come from software, from the event input, or from the block action of a finished descriptor. An event can arm a single skip of the next block-triggered pause.

States:
- IDLE (code 0)
- RUN (code 1)
- DRAIN (code 2): a pause is requested while a beat is in flight.
- HELD (code 3): paused.
- FAULT (code 4)

Transitions:
- IDLE→RUN on start.
- RUN→HELD on a pause request when no beat is in flight.
- RUN→DRAIN on a pause request while a beat is in flight.
- DRAIN→HELD once the beat ends.
- DRAIN→RUN on release.
- HELD→RUN on release.
- RUN or DRAIN→IDLE on the last block.
- RUN or DRAIN→FAULT on a bus error or bad descriptor.
- Any state→IDLE on abort.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, chan_state is 0 (IDLE). run_en, irq_flags, irq, evt_out and trig_out are all 0.
- R2: cmd_start in IDLE moves to RUN on the next edge, and run_en is 1 only in RUN. cmd_start in any other state has no effect.
- R3: In RUN, a pause request goes to HELD on the next edge when beat_busy is 0, and to DRAIN when beat_busy is 1. A pause request is cmd_hold, or evt_in with evt_act = 4. DRAIN stays until beat_busy is 0, then goes to HELD.
- R4: irq_flags bit 1 (paused) is set on the edge that enters HELD, and not before.
- R5: In HELD or DRAIN, a release request returns the channel to RUN. A release request is cmd_release, or evt_in with evt_act = 5. While HELD, block reports have no effect.
- R6: blk_done with blk_act bit 0 = 1 sets irq_flags bit 0 (block done). blk_act bit 1 = 1 pauses the channel after the block. So act 0 does nothing, act 1 sets the flag only, act 2 pauses only, and act 3 does both.
- R7: blk_done with blk_last = 1 returns the channel to IDLE. The pause bit of blk_act is ignored, and bit 0 still sets the block-done flag.
- R8: evt_in with evt_act = 6 arms a sticky skip bit. The skip bit cancels exactly one block-action pause and is then cleared.
- R9: bus_err or desc_bad in RUN or DRAIN moves the channel to FAULT and sets irq_flags bit 2. FAULT is left only by abort.
- R10: cmd_abort returns the channel to IDLE from any state on the next edge, and clears an armed skip. Abort takes priority over every other input.
- R11: Each irq_flags bit is cleared by writing 1 to the matching irq_clr bit. A set in the same cycle wins over the clear. irq is the OR of irq_flags AND irq_mask.
- R12: evt_out_sel selects the event output:
  - 0: no strobe.
  - 1: one-cycle strobe the cycle after a block completes in RUN or DRAIN.
  - 2: no strobe (reserved).
  - 3: one-cycle strobe the cycle after each beat_done in RUN or DRAIN.
- R13: evt_in with evt_act 1, 2 or 3 in RUN gives a one-cycle trig_out the next cycle, with trig_kind equal to the action code. Action 0 gives no trigger.
- R14: When CHAN_IDX is 4 or more, evt_in is ignored and evt_out and trig_out stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Software start pulse |
| cmd_hold | input | 1 | Software pause pulse |
| cmd_release | input | 1 | Software resume pulse |
| cmd_abort | input | 1 | Software abort pulse |
| evt_in | input | 1 | One-cycle channel event |
| evt_act | input | 3 | Action applied to evt_in |
| evt_out_sel | input | 2 | Event output select |
| beat_busy | input | 1 | Engine has a beat in flight |
| beat_done | input | 1 | Engine finished a beat |
| blk_done | input | 1 | Engine finished a block |
| blk_act | input | 2 | Block action of the finished descriptor |
| blk_last | input | 1 | Finished block ends the transaction |
| bus_err | input | 1 | Bus error from engine |
| desc_bad | input | 1 | Invalid descriptor fetched |
| irq_clr | input | 3 | Write-one-to-clear for flags |
| irq_mask | input | 3 | Interrupt enable per flag |
| run_en | output | 1 | Engine may issue beats |
| chan_state | output | 3 | Current state code |
| irq_flags | output | 3 | Flags: bit0 done, bit1 paused, bit2 fault |
| irq | output | 1 | Masked interrupt |
| evt_out | output | 1 | Event output strobe |
| trig_out | output | 1 | Transfer trigger strobe |
| trig_kind | output | 2 | Trigger action code |

## Verification
The bench builds two copies of the block that share every input. The first uses CHAN_IDX = 1, so the event input and event output are live, and every event action and output select can be driven. The second uses CHAN_IDX = 5, which selects the tied-off variant. Both copies receive the same pause events, event-output selects and trigger events. This makes it possible to show that only the low-numbered copy reacts, while the high-numbered copy keeps running with silent outputs.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_DRAIN = 3'd2,
        ST_HELD  = 3'd3,
        ST_FAULT = 3'd4
    } chan_st_e;

    localparam int FLAG_W   = 3;
    localparam int FL_DONE  = 0;
    localparam int FL_HOLD  = 1;
    localparam int FL_FAULT = 2;

    localparam logic [2:0] EA_NONE    = 3'd0;
    localparam logic [2:0] EA_TRIG    = 3'd1;
    localparam logic [2:0] EA_CTRIG   = 3'd2;
    localparam logic [2:0] EA_CBLOCK  = 3'd3;
    localparam logic [2:0] EA_HOLD    = 3'd4;
    localparam logic [2:0] EA_RELEASE = 3'd5;
    localparam logic [2:0] EA_SKIP    = 3'd6;

    localparam int BA_DONE_BIT = 0;
    localparam int BA_HOLD_BIT = 1;

    localparam logic [1:0] EO_OFF   = 2'd0;
    localparam logic [1:0] EO_BLOCK = 2'd1;
    localparam logic [1:0] EO_RSVD  = 2'd2;
    localparam logic [1:0] EO_BEAT  = 2'd3;

endpackage

// File: rtl/dcc_evt_decode.sv
module dcc_evt_decode
    import dcc_pkg::*;
#(
    parameter int CHAN_IDX  = 0,
    parameter int EVT_CHANS = 4
) (
    input  logic       evt_in,
    input  logic [2:0] evt_act,
    output logic       ev_hold,
    output logic       ev_release,
    output logic       ev_skip,
    output logic       ev_trig,
    output logic [1:0] ev_kind
);

    localparam bit HAS_EVT = (CHAN_IDX < EVT_CHANS);

    generate
        if (HAS_EVT) begin : g_live
            // Trigger family occupies codes 1..3; code 0 and 7 do nothing.
            always_comb begin
                ev_hold    = evt_in && (evt_act == EA_HOLD);
                ev_release = evt_in && (evt_act == EA_RELEASE);
                ev_skip    = evt_in && (evt_act == EA_SKIP);
                ev_trig    = evt_in && ((evt_act == EA_TRIG) ||
                                        (evt_act == EA_CTRIG) ||
                                        (evt_act == EA_CBLOCK));
                ev_kind    = evt_act[1:0];
            end
        end else begin : g_tied
            logic unused_evt;
            assign unused_evt = ^{evt_in, evt_act};
            always_comb begin
                ev_hold    = 1'b0;
                ev_release = 1'b0;
                ev_skip    = 1'b0;
                ev_trig    = 1'b0;
                ev_kind    = 2'd0;
            end
        end
    endgenerate

endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
    import dcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_start,
    input  logic       sw_hold,
    input  logic       sw_release,
    input  logic       sw_abort,
    input  logic       ev_hold,
    input  logic       ev_release,
    input  logic       ev_skip,
    input  logic       beat_busy,
    input  logic       blk_done,
    input  logic [1:0] blk_act,
    input  logic       blk_last,
    input  logic       bus_err,
    input  logic       desc_bad,
    output chan_st_e   state_q,
    output logic       run_en,
    output logic       set_done,
    output logic       set_hold,
    output logic       set_fault
);

    chan_st_e state_d;
    logic     skip_q;
    logic     skip_d;
    logic     hold_req;
    logic     rel_req;
    logic     fault_in;
    logic     blk_end;
    logic     blk_hold_hit;
    logic     skip_use;
    logic     moving;

    always_comb begin
        hold_req     = sw_hold | ev_hold;
        rel_req      = sw_release | ev_release;
        fault_in     = bus_err | desc_bad;
        blk_end      = blk_done & blk_last;
        blk_hold_hit = blk_done & blk_act[BA_HOLD_BIT] & ~blk_last;
        skip_use     = (state_q == ST_RUN) & blk_hold_hit & skip_q &
                       ~fault_in & ~sw_abort;
        moving       = (state_q == ST_RUN) || (state_q == ST_DRAIN);
    end

    // Next-state decision; abort overrides every branch.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sw_start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (fault_in)
                    state_d = ST_FAULT;
                else if (blk_end)
                    state_d = ST_IDLE;
                else if (hold_req || (blk_hold_hit && !skip_q))
                    state_d = beat_busy ? ST_DRAIN : ST_HELD;
            end
            ST_DRAIN: begin
                if (fault_in)
                    state_d = ST_FAULT;
                else if (blk_end)
                    state_d = ST_IDLE;
                else if (rel_req)
                    state_d = ST_RUN;
                else if (!beat_busy)
                    state_d = ST_HELD;
            end
            ST_HELD: begin
                if (rel_req) state_d = ST_RUN;
            end
            ST_FAULT: begin
                state_d = ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
        if (sw_abort) state_d = ST_IDLE;
    end

    always_comb begin
        skip_d = skip_q;
        if (sw_abort)
            skip_d = 1'b0;
        else if (ev_skip)
            skip_d = 1'b1;
        else if (skip_use)
            skip_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            skip_q  <= skip_d;
        end
    end

    // Output decode
    always_comb begin
        run_en    = (state_q == ST_RUN);
        set_done  = moving & blk_done & blk_act[BA_DONE_BIT] & ~sw_abort;
        set_hold  = (state_d == ST_HELD) & (state_q != ST_HELD);
        set_fault = (state_d == ST_FAULT) & (state_q != ST_FAULT);
    end

    assert_abort_to_idle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        sw_abort |=> (state_q == ST_IDLE) && !skip_q);

    assert_fault_entry_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && fault_in && !sw_abort) |=> (state_q == ST_FAULT));

    assert_fault_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FAULT) && !sw_abort) |=> (state_q == ST_FAULT));

    assert_drain_waits_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DRAIN) && beat_busy && !sw_abort && !fault_in &&
         !rel_req && !blk_end) |=> (state_q == ST_DRAIN));

    assert_skip_consumed_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (skip_use && !ev_skip) |=> !skip_q && (state_q == ST_RUN));

endmodule

// File: rtl/dcc_flags.sv
module dcc_flags
    import dcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set,
    input  logic [FLAG_W-1:0] clr,
    input  logic [FLAG_W-1:0] mask,
    output logic [FLAG_W-1:0] flags_q,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~clr) | set;
    end

    always_comb irq = |(flags_q & mask);

    assert_w1c_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        ((&clr) && (set == '0)) |=> (flags_q == '0));

    assert_set_wins_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags_q & $past(set)) == $past(set)));

endmodule

// File: rtl/dcc_evt_out.sv
module dcc_evt_out
    import dcc_pkg::*;
#(
    parameter int CHAN_IDX  = 0,
    parameter int EVT_CHANS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       beat_done,
    input  logic       blk_done,
    input  chan_st_e   state_q,
    input  logic       ev_trig,
    input  logic [1:0] ev_kind,
    output logic       evt_out,
    output logic       trig_out,
    output logic [1:0] trig_kind
);

    localparam bit HAS_EVT = (CHAN_IDX < EVT_CHANS);

    generate
        if (HAS_EVT) begin : g_live
            logic moving;
            logic strobe_d;

            always_comb begin
                moving   = (state_q == ST_RUN) || (state_q == ST_DRAIN);
                strobe_d = moving && (((sel == EO_BLOCK) && blk_done) ||
                                      ((sel == EO_BEAT)  && beat_done));
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    evt_out   <= 1'b0;
                    trig_out  <= 1'b0;
                    trig_kind <= 2'd0;
                end else begin
                    evt_out   <= strobe_d;
                    trig_out  <= ev_trig && (state_q == ST_RUN);
                    trig_kind <= ev_kind;
                end
            end

            assert_reserved_quiet_R12 : assert property (@(posedge clk) disable iff (!rst_n)
                ((sel == EO_RSVD) || (sel == EO_OFF)) |=> !evt_out);

            assert_trig_only_run_R13 : assert property (@(posedge clk) disable iff (!rst_n)
                (state_q != ST_RUN) |=> !trig_out);
        end else begin : g_tied
            logic unused_out;
            assign unused_out = ^{clk, rst_n, sel, beat_done, blk_done,
                                  state_q, ev_trig, ev_kind};
            always_comb begin
                evt_out   = 1'b0;
                trig_out  = 1'b0;
                trig_kind = 2'd0;
            end
        end
    endgenerate

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dcc_pkg::*;
#(
    parameter int CHAN_IDX  = 0,
    parameter int EVT_CHANS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_hold,
    input  logic       cmd_release,
    input  logic       cmd_abort,
    input  logic       evt_in,
    input  logic [2:0] evt_act,
    input  logic [1:0] evt_out_sel,
    input  logic       beat_busy,
    input  logic       beat_done,
    input  logic       blk_done,
    input  logic [1:0] blk_act,
    input  logic       blk_last,
    input  logic       bus_err,
    input  logic       desc_bad,
    input  logic [2:0] irq_clr,
    input  logic [2:0] irq_mask,
    output logic       run_en,
    output logic [2:0] chan_state,
    output logic [2:0] irq_flags,
    output logic       irq,
    output logic       evt_out,
    output logic       trig_out,
    output logic [1:0] trig_kind
);

    logic       ev_hold;
    logic       ev_release;
    logic       ev_skip;
    logic       ev_trig;
    logic [1:0] ev_kind;
    chan_st_e   state_q;
    logic       set_done;
    logic       set_hold;
    logic       set_fault;
    logic [FLAG_W-1:0] flag_set;

    dcc_evt_decode #(.CHAN_IDX(CHAN_IDX), .EVT_CHANS(EVT_CHANS)) u_dec (
        .evt_in     (evt_in),
        .evt_act    (evt_act),
        .ev_hold    (ev_hold),
        .ev_release (ev_release),
        .ev_skip    (ev_skip),
        .ev_trig    (ev_trig),
        .ev_kind    (ev_kind)
    );

    dcc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_start   (cmd_start),
        .sw_hold    (cmd_hold),
        .sw_release (cmd_release),
        .sw_abort   (cmd_abort),
        .ev_hold    (ev_hold),
        .ev_release (ev_release),
        .ev_skip    (ev_skip),
        .beat_busy  (beat_busy),
        .blk_done   (blk_done),
        .blk_act    (blk_act),
        .blk_last   (blk_last),
        .bus_err    (bus_err),
        .desc_bad   (desc_bad),
        .state_q    (state_q),
        .run_en     (run_en),
        .set_done   (set_done),
        .set_hold   (set_hold),
        .set_fault  (set_fault)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FL_DONE]  = set_done;
        flag_set[FL_HOLD]  = set_hold;
        flag_set[FL_FAULT] = set_fault;
    end

    dcc_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (flag_set),
        .clr     (irq_clr),
        .mask    (irq_mask),
        .flags_q (irq_flags),
        .irq     (irq)
    );

    dcc_evt_out #(.CHAN_IDX(CHAN_IDX), .EVT_CHANS(EVT_CHANS)) u_eout (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (evt_out_sel),
        .beat_done (beat_done),
        .blk_done  (blk_done),
        .state_q   (state_q),
        .ev_trig   (ev_trig),
        .ev_kind   (ev_kind),
        .evt_out   (evt_out),
        .trig_out  (trig_out),
        .trig_kind (trig_kind)
    );

    assign chan_state = state_q;

    assert_hold_flag_on_entry_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[FL_HOLD]) |-> (state_q == ST_HELD));

    assert_run_gate_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !cmd_start) |=> !run_en);

endmodule

// File: tb/dma_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_hold = 0, cmd_release = 0, cmd_abort = 0;
    logic evt_in = 0;
    logic [2:0] evt_act = 0;
    logic [1:0] evt_out_sel = 0;
    logic beat_busy = 0, beat_done = 0, blk_done = 0, blk_last = 0;
    logic [1:0] blk_act = 0;
    logic bus_err = 0, desc_bad = 0;
    logic [2:0] irq_clr = 0, irq_mask = 0;

    logic run_en, irq, evt_out, trig_out;
    logic [2:0] chan_state, irq_flags;
    logic [1:0] trig_kind;
    logic hi_run_en, hi_irq, hi_evt_out, hi_trig_out;
    logic [2:0] hi_state, hi_flags;
    logic [1:0] hi_kind;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dma_chan_ctrl #(.CHAN_IDX(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_hold(cmd_hold),
        .cmd_release(cmd_release), .cmd_abort(cmd_abort), .evt_in(evt_in),
        .evt_act(evt_act), .evt_out_sel(evt_out_sel), .beat_busy(beat_busy),
        .beat_done(beat_done), .blk_done(blk_done), .blk_act(blk_act),
        .blk_last(blk_last), .bus_err(bus_err), .desc_bad(desc_bad),
        .irq_clr(irq_clr), .irq_mask(irq_mask), .run_en(run_en),
        .chan_state(chan_state), .irq_flags(irq_flags), .irq(irq),
        .evt_out(evt_out), .trig_out(trig_out), .trig_kind(trig_kind));

    dma_chan_ctrl #(.CHAN_IDX(5)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_hold(cmd_hold),
        .cmd_release(cmd_release), .cmd_abort(cmd_abort), .evt_in(evt_in),
        .evt_act(evt_act), .evt_out_sel(evt_out_sel), .beat_busy(beat_busy),
        .beat_done(beat_done), .blk_done(blk_done), .blk_act(blk_act),
        .blk_last(blk_last), .bus_err(bus_err), .desc_bad(desc_bad),
        .irq_clr(irq_clr), .irq_mask(irq_mask), .run_en(hi_run_en),
        .chan_state(hi_state), .irq_flags(hi_flags), .irq(hi_irq),
        .evt_out(hi_evt_out), .trig_out(hi_trig_out), .trig_kind(hi_kind));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_pulses();
        cmd_start = 0; cmd_hold = 0; cmd_release = 0; cmd_abort = 0;
        evt_in = 0; evt_act = 0; beat_done = 0; blk_done = 0; blk_act = 0;
        blk_last = 0; bus_err = 0; desc_bad = 0; irq_clr = 0;
    endtask

    task automatic go_idle();
        cmd_abort = 1; irq_clr = 3'b111; tick(); clear_pulses();
    endtask

    task automatic go_run();
        go_idle();
        cmd_start = 1; tick(); clear_pulses();
    endtask

    task automatic t_reset();
        chk("R1", "state", chan_state, 0);
        chk("R1", "run_en", run_en, 0);
        chk("R1", "flags", irq_flags, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "evt_out", evt_out, 0);
        chk("R1", "trig_out", trig_out, 0);
    endtask

    task automatic t_sw_hold();
        go_run();
        chk("R2", "start to RUN", chan_state, 1);
        chk("R2", "run_en in RUN", run_en, 1);
        cmd_hold = 1; beat_busy = 0; tick(); clear_pulses();
        chk("R3", "hold no beat -> HELD", chan_state, 3);
        chk("R3", "run_en held", run_en, 0);
        chk("R4", "paused flag on entry", irq_flags, 3'b010);
        blk_done = 1; blk_act = 2'd1; tick(); clear_pulses();
        chk("R5", "block ignored while HELD", chan_state, 3);
        chk("R5", "no done flag while HELD", irq_flags, 3'b010);
        cmd_release = 1; tick(); clear_pulses();
        chk("R5", "sw release", chan_state, 1);
        irq_clr = 3'b010; tick(); clear_pulses();
        chk("R11", "w1c paused", irq_flags, 0);
    endtask

    task automatic t_drain();
        go_run();
        beat_busy = 1; evt_in = 1; evt_act = 3'd4; tick(); clear_pulses();
        chk("R3", "event hold mid-beat -> DRAIN", chan_state, 2);
        chk("R4", "no flag in DRAIN", irq_flags, 0);
        chk("R14", "high channel ignores event", hi_state, 1);
        tick();
        chk("R3", "DRAIN waits", chan_state, 2);
        beat_busy = 0; tick();
        chk("R3", "DRAIN -> HELD", chan_state, 3);
        chk("R4", "flag at HELD entry", irq_flags, 3'b010);
        evt_in = 1; evt_act = 3'd5; tick(); clear_pulses();
        chk("R5", "event release", chan_state, 1);
    endtask

    task automatic t_block();
        go_run();
        evt_out_sel = 2'd1;
        blk_done = 1; blk_act = 2'd0; tick(); clear_pulses();
        chk("R6", "act0 stays RUN", chan_state, 1);
        chk("R6", "act0 no flag", irq_flags, 0);
        chk("R12", "block strobe", evt_out, 1);
        chk("R14", "high channel no strobe", hi_evt_out, 0);
        tick();
        chk("R12", "strobe one cycle", evt_out, 0);
        blk_done = 1; blk_act = 2'd1; tick(); clear_pulses();
        chk("R6", "act1 done flag", irq_flags, 3'b001);
        chk("R6", "act1 stays RUN", chan_state, 1);
        irq_clr = 3'b111; tick(); clear_pulses();
        blk_done = 1; blk_act = 2'd2; tick(); clear_pulses();
        chk("R6", "act2 pauses", chan_state, 3);
        chk("R6", "act2 paused flag only", irq_flags, 3'b010);
        cmd_release = 1; irq_clr = 3'b111; tick(); clear_pulses();
        blk_done = 1; blk_act = 2'd3; tick(); clear_pulses();
        chk("R6", "act3 pauses", chan_state, 3);
        chk("R6", "act3 both flags", irq_flags, 3'b011);
        evt_out_sel = 2'd0;
    endtask

    task automatic t_skip();
        go_run();
        evt_in = 1; evt_act = 3'd6; tick(); clear_pulses();
        blk_done = 1; blk_act = 2'd2; tick(); clear_pulses();
        chk("R8", "skip cancels pause", chan_state, 1);
        blk_done = 1; blk_act = 2'd2; tick(); clear_pulses();
        chk("R8", "skip used once", chan_state, 3);
        go_idle();
        evt_in = 1; evt_act = 3'd6; tick(); clear_pulses();
        cmd_abort = 1; tick(); clear_pulses();
        cmd_start = 1; tick(); clear_pulses();
        blk_done = 1; blk_act = 2'd2; tick(); clear_pulses();
        chk("R10", "abort cleared skip", chan_state, 3);
    endtask

    task automatic t_last();
        go_run();
        blk_done = 1; blk_act = 2'd3; blk_last = 1; tick(); clear_pulses();
        chk("R7", "last block -> IDLE", chan_state, 0);
        chk("R7", "done flag, no pause flag", irq_flags, 3'b001);
    endtask

    task automatic t_fault();
        go_run();
        bus_err = 1; tick(); clear_pulses();
        chk("R9", "bus error -> FAULT", chan_state, 4);
        chk("R9", "fault flag", irq_flags, 3'b100);
        chk("R9", "run_en off", run_en, 0);
        cmd_start = 1; tick(); clear_pulses();
        chk("R2", "start ignored in FAULT", chan_state, 4);
        cmd_release = 1; tick(); clear_pulses();
        chk("R9", "release ignored in FAULT", chan_state, 4);
        cmd_abort = 1; tick(); clear_pulses();
        chk("R10", "abort from FAULT", chan_state, 0);
        go_run();
        beat_busy = 1; cmd_hold = 1; tick(); clear_pulses();
        desc_bad = 1; tick(); clear_pulses();
        beat_busy = 0;
        chk("R9", "bad descriptor in DRAIN -> FAULT", chan_state, 4);
        cmd_abort = 1; tick(); clear_pulses();
        chk("R10", "abort to IDLE", chan_state, 0);
    endtask

    task automatic t_irq();
        go_idle();
        irq_mask = 3'b100;
        go_run();
        blk_done = 1; blk_act = 2'd1; tick(); clear_pulses();
        chk("R11", "masked irq low", irq, 0);
        irq_mask = 3'b001; #1;
        chk("R11", "unmasked irq high", irq, 1);
        irq_clr = 3'b001; blk_done = 1; blk_act = 2'd1; tick(); clear_pulses();
        chk("R11", "set wins over clear", irq_flags[0], 1);
        irq_clr = 3'b001; tick(); clear_pulses();
        chk("R11", "cleared", irq_flags, 0);
        chk("R11", "irq low", irq, 0);
        irq_mask = 3'b000;
    endtask

    task automatic t_beat_evt();
        go_run();
        evt_out_sel = 2'd3;
        beat_done = 1; tick(); clear_pulses();
        chk("R12", "beat strobe", evt_out, 1);
        chk("R14", "high channel quiet", hi_evt_out, 0);
        tick();
        chk("R12", "beat strobe ends", evt_out, 0);
        evt_out_sel = 2'd2;
        beat_done = 1; blk_done = 1; tick(); clear_pulses();
        chk("R12", "reserved select silent", evt_out, 0);
        evt_out_sel = 2'd0;
        beat_done = 1; blk_done = 1; tick(); clear_pulses();
        chk("R12", "disabled select silent", evt_out, 0);
    endtask

    task automatic t_trig();
        go_run();
        evt_in = 1; evt_act = 3'd1; tick(); clear_pulses();
        chk("R13", "trigger strobe", trig_out, 1);
        chk("R13", "trigger kind 1", trig_kind, 1);
        chk("R14", "high channel no trigger", hi_trig_out, 0);
        tick();
        chk("R13", "trigger one cycle", trig_out, 0);
        evt_in = 1; evt_act = 3'd3; tick(); clear_pulses();
        chk("R13", "trigger kind 3", trig_kind, 3);
        evt_in = 1; evt_act = 3'd0; tick(); clear_pulses();
        chk("R13", "action 0 no trigger", trig_out, 0);
        chk("R13", "action 0 keeps RUN", chan_state, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_sw_hold();
        t_drain();
        t_block();
        t_skip();
        t_last();
        t_fault();
        t_irq();
        t_beat_evt();
        t_trig();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule